// File: doc/BRIEF.md
# Floating-Point Recoding Converter Pair

This block holds two combinational converters that sit at the edge of a floating-point unit. The encoder takes a value in the standard binary interchange layout (sign, biased exponent, trailing fraction) and produces a recoded word that has one more exponent bit. The decoder performs the reverse mapping. In the recoded word the three top exponent bits mark the special classes: zero, infinity and NaN. Subnormal inputs are normalized, so arithmetic downstream treats them like normal numbers.

Both directions are exact. Every standard encoding maps to one value-equal recoded word and comes back unchanged, and no exception is ever raised. The format is set by two parameters: the exponent width `EXP_W` (w) and the precision `SIG_W` (p, which counts the hidden bit). The standard word has w+p bits and the recoded word has w+p+1 bits. In the text below, k = w−1. The recoded layout is, from the top bit down: sign, then the w+1 exponent bits, then the p−1 fraction bits. The decoder does not screen malformed recoded words.

Top module: `fp_recode_pair`

## Requirements
- R1: A normal input with biased exponent E (0 < E < 2^w−1) is encoded with recoded exponent E + 2^k + 1. Its sign and fraction are copied unchanged.
- R2: A subnormal input (exponent 0, fraction nonzero) is normalized. Let n be the number of leading zeros of the fraction plus one. The fraction is shifted left by n bits and only the low p−1 bits are kept, which drops the leading 1. The recoded exponent is 2^k + 2 − n.
- R3: A zero input is encoded with its sign kept, a recoded exponent of all zeros (top three bits 000) and a zero fraction.
- R4: An infinity is encoded with its sign kept, the exponent top bits set to 110 and all lower exponent bits zero, and a zero fraction.
- R5: A NaN is encoded with its sign kept, the exponent top bits set to 111 and all lower exponent bits zero, and its fraction copied. A quiet NaN therefore keeps its fraction MSB set, and a signaling NaN keeps it clear.
- R6: The decoder treats a recoded exponent X as a normal number when its top three bits are not 000, 110 or 111 and X ≥ 2^k + 2. It outputs standard exponent X − 2^k − 1, and it copies the sign and fraction.
- R7: The decoder treats a recoded exponent X below 2^k + 2 with a non-special tag as a subnormal. It outputs exponent 0 and the fraction equal to the low p−1 bits of ({1, fraction} >> (2^k + 2 − X)).
- R8: The decoder maps tag 000 to a signed zero. It maps tag 110 to an infinity (all-ones exponent, zero fraction) and ignores the recoded fraction. It maps tag 111 to a NaN with an all-ones exponent and the fraction copied.
- R9: Decoding the encoder's output returns the original standard word bit for bit, for every class: zero, subnormal, normal, infinity and NaN.
- R10: Every finite nonzero recoded exponent produced by the encoder lies between 2^k + 3 − p and 3·2^k − 1, inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| stdIn | input | EXP_W+SIG_W | Standard-layout value to be recoded |
| recOut | output | EXP_W+SIG_W+1 | Recoded form of stdIn |
| recIn | input | EXP_W+SIG_W+1 | Recoded value to be converted back |
| stdOut | output | EXP_W+SIG_W | Standard-layout form of recIn |

## Verification
The bench builds two copies of the block: one with w=8, p=24 (single precision) and one with w=5, p=11 (half precision). In the half build, the whole recoded exponent range is small: 8 to 47. The extremes of both ranges are checked, along with the smallest and largest subnormal and normal values of each format. In the single build, leading-zero counts reach 22, which exercises the deep end of the normalizing shifter. Random round trips sorted by class are run on both builds. These round trips show that the rebias constants and the shift directions are consistent for more than one value of k.

// File: rtl/fp_recode_pkg.sv
package fp_recode_pkg;

  // Class strobes shared by the classifiers (control) and the data paths.
  typedef struct packed {
    logic isZero;
    logic isSub;
    logic isInf;
    logic isNaN;
  } fpClass_t;

  localparam logic [2:0] TAG_ZERO = 3'b000;
  localparam logic [2:0] TAG_INF  = 3'b110;
  localparam logic [2:0] TAG_NAN  = 3'b111;

endpackage

// File: rtl/fp_std_classify.sv
module fp_std_classify
  import fp_recode_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int SIG_W = 24
) (
  input  logic [EXP_W-1:0] expIn,
  input  logic [SIG_W-2:0] fracIn,
  output fpClass_t         cls
);

  logic expZero, expOnes, fracZero;

  always_comb begin
    expZero    = (expIn == '0);
    expOnes    = &expIn;
    fracZero   = (fracIn == '0);
    cls.isZero = expZero && fracZero;
    cls.isSub  = expZero && !fracZero;
    cls.isInf  = expOnes && fracZero;
    cls.isNaN  = expOnes && !fracZero;
  end

endmodule

// File: rtl/fp_rec_classify.sv
module fp_rec_classify
  import fp_recode_pkg::*;
#(
  parameter int EXP_W = 8
) (
  input  logic [EXP_W:0] expIn,
  output fpClass_t       cls
);

  localparam int K        = EXP_W - 1;
  localparam int NORM_MIN = (1 << K) + 2;

  logic [2:0] tag;
  logic       special;

  always_comb begin
    tag        = expIn[EXP_W -: 3];
    cls.isZero = (tag == TAG_ZERO);
    cls.isInf  = (tag == TAG_INF);
    cls.isNaN  = (tag == TAG_NAN);
    special    = cls.isZero || cls.isInf || cls.isNaN;
    cls.isSub  = !special && (int'(expIn) < NORM_MIN);
  end

endmodule

// File: rtl/fp_encode_path.sv
module fp_encode_path
  import fp_recode_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int SIG_W = 24
) (
  input  logic                 signIn,
  input  logic [EXP_W-1:0]     expIn,
  input  logic [SIG_W-2:0]     fracIn,
  input  fpClass_t             cls,
  output logic [EXP_W+SIG_W:0] recOut
);

  localparam int FRAC_W   = SIG_W - 1;
  localparam int REXP_W   = EXP_W + 1;
  localparam int K        = EXP_W - 1;
  localparam int CNT_W    = $clog2(FRAC_W + 1);
  localparam int BIAS_ADJ = (1 << K) + 1;
  localparam int NORM_MIN = (1 << K) + 2;

  function automatic logic [CNT_W-1:0] leadZeros(input logic [FRAC_W-1:0] v);
    logic [CNT_W-1:0] c;
    logic             hit;
    c   = '0;
    hit = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      c   = c + CNT_W'(1);
      end
    end
    return c;
  endfunction

  logic [CNT_W-1:0]  shiftN;
  logic [FRAC_W-1:0] normFrac;
  logic [REXP_W-1:0] subExp, normExp, recExp;
  logic [FRAC_W-1:0] recFrac;

  always_comb begin
    shiftN   = leadZeros(fracIn) + CNT_W'(1);
    normFrac = fracIn << shiftN;
    subExp   = REXP_W'(NORM_MIN) - REXP_W'(shiftN);
    normExp  = REXP_W'(expIn) + REXP_W'(BIAS_ADJ);
    if (cls.isZero) begin
      recExp  = {TAG_ZERO, {(REXP_W-3){1'b0}}};
      recFrac = '0;
    end else if (cls.isInf) begin
      recExp  = {TAG_INF, {(REXP_W-3){1'b0}}};
      recFrac = '0;
    end else if (cls.isNaN) begin
      recExp  = {TAG_NAN, {(REXP_W-3){1'b0}}};
      recFrac = fracIn;
    end else if (cls.isSub) begin
      recExp  = subExp;
      recFrac = normFrac;
    end else begin
      recExp  = normExp;
      recFrac = fracIn;
    end
    recOut = {signIn, recExp, recFrac};
  end

endmodule

// File: rtl/fp_decode_path.sv
module fp_decode_path
  import fp_recode_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int SIG_W = 24
) (
  input  logic                   signIn,
  input  logic [EXP_W:0]         expIn,
  input  logic [SIG_W-2:0]       fracIn,
  input  fpClass_t               cls,
  output logic [EXP_W+SIG_W-1:0] stdOut
);

  localparam int FRAC_W   = SIG_W - 1;
  localparam int REXP_W   = EXP_W + 1;
  localparam int K        = EXP_W - 1;
  localparam int BIAS_ADJ = (1 << K) + 1;
  localparam int NORM_MIN = (1 << K) + 2;

  logic [REXP_W-1:0] subShift, normExpW;
  logic [FRAC_W:0]   wideFrac;
  logic [EXP_W-1:0]  outExp;
  logic [FRAC_W-1:0] outFrac;

  always_comb begin
    subShift = REXP_W'(NORM_MIN) - expIn;
    wideFrac = {1'b1, fracIn} >> subShift;
    normExpW = expIn - REXP_W'(BIAS_ADJ);
    if (cls.isZero) begin
      outExp  = '0;
      outFrac = '0;
    end else if (cls.isInf) begin
      outExp  = '1;
      outFrac = '0;
    end else if (cls.isNaN) begin
      outExp  = '1;
      outFrac = fracIn;
    end else if (cls.isSub) begin
      outExp  = '0;
      outFrac = wideFrac[FRAC_W-1:0];
    end else begin
      outExp  = normExpW[EXP_W-1:0];
      outFrac = fracIn;
    end
    stdOut = {signIn, outExp, outFrac};
  end

endmodule

// File: rtl/fp_recode_pair.sv
module fp_recode_pair
  import fp_recode_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int SIG_W = 24
) (
  input  logic [EXP_W+SIG_W-1:0] stdIn,
  output logic [EXP_W+SIG_W:0]   recOut,
  input  logic [EXP_W+SIG_W:0]   recIn,
  output logic [EXP_W+SIG_W-1:0] stdOut
);

  localparam int FRAC_W = SIG_W - 1;

  fpClass_t stdCls, recCls;

  fp_std_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) uStdCls (
    .expIn (stdIn[FRAC_W +: EXP_W]),
    .fracIn(stdIn[FRAC_W-1:0]),
    .cls   (stdCls)
  );

  fp_encode_path #(.EXP_W(EXP_W), .SIG_W(SIG_W)) uEnc (
    .signIn(stdIn[EXP_W+SIG_W-1]),
    .expIn (stdIn[FRAC_W +: EXP_W]),
    .fracIn(stdIn[FRAC_W-1:0]),
    .cls   (stdCls),
    .recOut(recOut)
  );

  fp_rec_classify #(.EXP_W(EXP_W)) uRecCls (
    .expIn(recIn[FRAC_W +: EXP_W+1]),
    .cls  (recCls)
  );

  fp_decode_path #(.EXP_W(EXP_W), .SIG_W(SIG_W)) uDec (
    .signIn(recIn[EXP_W+SIG_W]),
    .expIn (recIn[FRAC_W +: EXP_W+1]),
    .fracIn(recIn[FRAC_W-1:0]),
    .cls   (recCls),
    .stdOut(stdOut)
  );

endmodule

// File: rtl/fp_recode_checker.sv
module fp_recode_checker #(
  parameter int EXP_W = 8,
  parameter int SIG_W = 24
) (
  input logic [EXP_W+SIG_W-1:0] stdIn,
  input logic [EXP_W+SIG_W:0]   recOut,
  input logic [EXP_W+SIG_W:0]   recIn,
  input logic [EXP_W+SIG_W-1:0] stdOut
);

  localparam int FRAC_W   = SIG_W - 1;
  localparam int K        = EXP_W - 1;
  localparam int EXP_MIN  = (1 << K) + 3 - SIG_W;
  localparam int EXP_MAX  = 3 * (1 << K) - 1;
  localparam int NORM_MIN = (1 << K) + 2;

  logic [EXP_W-1:0] sExp;
  logic [FRAC_W-1:0] sFrac;
  logic [EXP_W:0]   oExp, iExp;
  logic [2:0]       oTag, iTag;

  always_comb begin
    sExp  = stdIn[FRAC_W +: EXP_W];
    sFrac = stdIn[FRAC_W-1:0];
    oExp  = recOut[FRAC_W +: EXP_W+1];
    iExp  = recIn[FRAC_W +: EXP_W+1];
    oTag  = oExp[EXP_W -: 3];
    iTag  = iExp[EXP_W -: 3];

    p_sign_kept_r1: assert (recOut[EXP_W+SIG_W] == stdIn[EXP_W+SIG_W-1])
      else $error("encoder changed the sign");
    p_zero_tag_r3: assert (!(sExp == '0 && sFrac == '0) || oExp == '0)
      else $error("zero not recoded with a clear exponent");
    p_inf_tag_r4: assert (!(&sExp && sFrac == '0) || oTag == 3'b110)
      else $error("infinity tag wrong");
    p_nan_frac_r5: assert (!(&sExp && sFrac != '0) ||
                           (oTag == 3'b111 && recOut[FRAC_W-1:0] == sFrac))
      else $error("NaN tag or payload wrong");
    p_exp_range_r10: assert (oTag == 3'b000 || oTag == 3'b110 || oTag == 3'b111 ||
                             (int'(oExp) >= EXP_MIN && int'(oExp) <= EXP_MAX))
      else $error("recoded exponent out of range");
    p_sub_decode_r7: assert (iTag == 3'b000 || iTag == 3'b110 || iTag == 3'b111 ||
                             int'(iExp) >= NORM_MIN || stdOut[FRAC_W +: EXP_W] == '0)
      else $error("subnormal decode exponent not zero");
    p_special_decode_r8: assert (!(iTag == 3'b110 || iTag == 3'b111) ||
                                 &stdOut[FRAC_W +: EXP_W])
      else $error("special decode exponent not all ones");
  end

endmodule

bind fp_recode_pair fp_recode_checker #(.EXP_W(EXP_W), .SIG_W(SIG_W)) uChk (
  .stdIn (stdIn),
  .recOut(recOut),
  .recIn (recIn),
  .stdOut(stdOut)
);

// File: tb/sim_fp_recode_pair.sv
module sim_fp_recode_pair;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] stdIn32 = '0, stdOut32;
  logic [32:0] recOut32, recIn32 = '0;
  logic [15:0] stdIn16 = '0, stdOut16;
  logic [16:0] recOut16, recIn16 = '0;

  int nChecks = 0;
  int nErr    = 0;

  fp_recode_pair #(.EXP_W(8), .SIG_W(24)) u0 (
    .stdIn(stdIn32), .recOut(recOut32), .recIn(recIn32), .stdOut(stdOut32));

  fp_recode_pair #(.EXP_W(5), .SIG_W(11)) uHalf (
    .stdIn(stdIn16), .recOut(recOut16), .recIn(recIn16), .stdOut(stdOut16));

  // {standard single, expected recoded}
  localparam int NV = 14;
  localparam logic [64:0] VEC [NV] = '{
    {32'h3F800000, 33'h080000000},  // R1 one
    {32'hC0200000, 33'h180A00000},  // R1 -2.5
    {32'h00800000, 33'h041000000},  // R1 min normal
    {32'h7F7FFFFF, 33'h0BFFFFFFF},  // R1 max normal, R10 top
    {32'h00000001, 33'h035800000},  // R2 min subnormal, R10 bottom
    {32'h007FFFFF, 33'h040FFFFFE},  // R2 max subnormal
    {32'h80400000, 33'h140800000},  // R2 negative subnormal
    {32'h00012345, 33'h03D91A280},  // R2 shift by 7
    {32'h00000000, 33'h000000000},  // R3 +0
    {32'h80000000, 33'h100000000},  // R3 -0
    {32'h7F800000, 33'h0C0000000},  // R4 +inf
    {32'hFF800000, 33'h1C0000000},  // R4 -inf
    {32'h7FC00000, 33'h0E0400000},  // R5 quiet NaN
    {32'hFF800001, 33'h1E0000001}   // R5 signaling NaN
  };

  task automatic chk(input bit ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic trip32(input logic [31:0] s);
    @(posedge clk);
    stdIn32 = s;
    @(negedge clk);
    recIn32 = recOut32;
    #1;
  endtask

  task automatic trip16(input logic [15:0] s);
    @(posedge clk);
    stdIn16 = s;
    @(negedge clk);
    recIn16 = recOut16;
    #1;
  endtask

  function automatic logic [31:0] mk32(input int cls);
    logic [22:0] f = 23'($urandom);
    logic [7:0]  e = 8'($urandom_range(1, 254));
    logic        s = 1'($urandom);
    case (cls)
      0: return {s, 8'h00, 23'h0};
      1: return {s, 8'h00, (f == 0) ? 23'h1 : f};
      2: return {s, e, f};
      3: return {s, 8'hFF, 23'h0};
      default: return {s, 8'hFF, (f == 0) ? 23'h1 : f};
    endcase
  endfunction

  function automatic logic [15:0] mk16(input int cls);
    logic [9:0] f = 10'($urandom);
    logic [4:0] e = 5'($urandom_range(1, 30));
    logic       s = 1'($urandom);
    case (cls)
      0: return {s, 5'h00, 10'h0};
      1: return {s, 5'h00, (f == 0) ? 10'h1 : f};
      2: return {s, e, f};
      3: return {s, 5'h1F, 10'h0};
      default: return {s, 5'h1F, (f == 0) ? 10'h1 : f};
    endcase
  endfunction

  bit finished = 0;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    nChecks++;
    nErr++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: inputs held at zero -> both outputs zero (R3, R8)
    chk(recOut32 == '0, "R3 reset recOut", 64'(recOut32), 64'h0);
    chk(stdOut32 == '0, "R8 reset stdOut", 64'(stdOut32), 64'h0);
    rst = 1'b0;

    // vector table: encode, then decode back (R9)
    for (int i = 0; i < NV; i++) begin
      trip32(VEC[i][64:33]);
      chk(recOut32 == VEC[i][32:0], "R1/R2/R3/R4/R5 table encode",
          64'(recOut32), 64'(VEC[i][32:0]));
      chk(stdOut32 == VEC[i][64:33], "R6/R7/R8/R9 table decode",
          64'(stdOut32), 64'(VEC[i][64:33]));
    end

    // R8: infinity with stray fraction decodes to clean infinity
    @(posedge clk);
    recIn32 = 33'h0C0001234;
    @(negedge clk);
    chk(stdOut32 == 32'h7F800000, "R8 inf fraction ignored", 64'(stdOut32), 64'h7F800000);
    @(posedge clk);
    recIn32 = 33'h1E0012345;
    @(negedge clk);
    chk(stdOut32 == 32'hFF812345, "R8 NaN payload kept", 64'(stdOut32), 64'hFF812345);
    // R6: smallest normal recoded exponent 130 -> E=1
    @(posedge clk);
    recIn32 = {1'b0, 9'd130, 23'h000055};
    @(negedge clk);
    chk(stdOut32 == 32'h00800055, "R6 min normal decode", 64'(stdOut32), 64'h00800055);
    // R7: exponent 129 -> shift by 1
    @(posedge clk);
    recIn32 = {1'b1, 9'd129, 23'h000002};
    @(negedge clk);
    chk(stdOut32 == 32'h80400001, "R7 subnormal decode", 64'(stdOut32), 64'h80400001);

    // half-precision boundaries
    trip16(16'h3C00);
    chk(recOut16 == 17'h08000, "R1 half one", 64'(recOut16), 64'h08000);
    trip16(16'h0001);
    chk(recOut16 == 17'h02000, "R2 R10 half min subnormal", 64'(recOut16), 64'h02000);
    chk(stdOut16 == 16'h0001, "R9 half min subnormal", 64'(stdOut16), 64'h0001);
    trip16(16'h03FF);
    chk(recOut16 == 17'h047FE, "R2 half max subnormal", 64'(recOut16), 64'h047FE);
    chk(stdOut16 == 16'h03FF, "R9 half max subnormal", 64'(stdOut16), 64'h03FF);
    trip16(16'h7BFF);
    chk(recOut16 == 17'h0BFFF, "R1 R10 half max normal", 64'(recOut16), 64'h0BFFF);
    trip16(16'hFC00);
    chk(recOut16 == 17'h1C000, "R4 half -inf", 64'(recOut16), 64'h1C000);
    trip16(16'h7E00);
    chk(recOut16 == 17'h0E200, "R5 half quiet NaN", 64'(recOut16), 64'h0E200);

    // random round trips per class, both formats (R9, R10)
    for (int c = 0; c < 5; c++) begin
      for (int j = 0; j < 200; j++) begin
        logic [31:0] a;
        logic [15:0] h;
        int          x;
        a = mk32(c);
        trip32(a);
        chk(stdOut32 == a, "R9 single round trip", 64'(stdOut32), 64'(a));
        x = int'(recOut32[31:23]);
        if (c == 1 || c == 2)
          chk(x >= 107 && x <= 383, "R10 single exponent range", 64'(x), 64'd107);
        h = mk16(c);
        trip16(h);
        chk(stdOut16 == h, "R9 half round trip", 64'(stdOut16), 64'(h));
        x = int'(recOut16[15:10]);
        if (c == 1 || c == 2)
          chk(x >= 8 && x <= 47, "R10 half exponent range", 64'(x), 64'd8);
      end
    end

    summary();
  end

endmodule